// File: doc/BRIEF.md
# Block-Based Partial Configuration Loader

This controller takes a byte stream on an 8-bit input and applies partial updates to an on-chip store of configuration frames. The frames are grouped in blocks of eight, so one byte position of all eight frames in a block forms an 8-byte slice. The byte width of the input matches the number of frames per block. A transfer opens with a two-byte header: the first byte is the number of the first block to touch, and the second byte says how many consecutive blocks follow.

For every slice of the current block, the stream carries one mask byte. The mask names the frames whose byte in that slice is to be replaced. Only the replacement bytes for the flagged frames follow. The controller reads the slice into an 8-byte holding register in one cycle. It overwrites the flagged lanes as the bytes arrive and writes the merged slice back in one cycle. Unflagged bytes keep their old contents. A combinational readback port exposes any stored byte, so the contents of the store can be observed.

Top module: `pcfg_loader`

## Requirements
- R1: After reset, busy and err are 0 and every stored byte reads back as 0.
- R2: The first accepted byte of a header is the start block and the second is the block count. For a legal non-zero count, busy is 1 from the cycle after the count byte is accepted.
- R3: Within a block, slices are walked from byte offset 0 up to FRAME_BYTES-1, one mask byte per slice. Mask bit j selects frame block*8+j at that byte offset.
- R4: Replacement bytes fill the flagged frames from the highest set mask bit down to the lowest. Frames whose bit is clear keep their previous byte.
- R5: A mask byte of 0 consumes no data byte, writes nothing, and moves on to the next slice.
- R6: After the last slice of a block the walk continues at offset 0 of the next block. After the last slice of the last counted block busy falls, and the next byte is taken as a new header.
- R7: If start block plus count exceeds NUM_BLOCKS, err is 1 from the cycle after the count byte, busy stays 0 and nothing is written. err returns to 0 once the next header start byte is accepted.
- R8: A count of 0 writes nothing, leaves busy at 0 and does not raise err.
- R9: Cycles with in_valid low change neither the transfer state nor the store.
- R10: rd_data shows frame rd_frame at byte offset rd_byte combinationally. A slice write becomes visible right after the clock edge that accepts its last replacement byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_byte holds a stream byte this cycle |
| in_byte | input | 8 | Header, mask or replacement byte |
| busy | output | 1 | A block walk is in progress |
| err | output | 1 | The last header named blocks beyond the store |
| rd_frame | input | $clog2(NUM_BLOCKS*8) | Frame index for readback |
| rd_byte | input | $clog2(FRAME_BYTES) | Byte offset for readback |
| rd_data | output | 8 | Stored byte at the readback address |

## Verification
Each byte is accepted on a rising edge, so busy and err are due one edge after the count byte. A written slice is due one edge after its last replacement byte. rd_data follows its address without any delay. The bench drives a byte on a falling edge and samples the flags, and the readback a short delay after setting its address, on the next falling edge. Every result it checks has therefore settled exactly one edge after its stimulus. Idle gaps in the middle of a transfer show that nothing advances while in_valid is low.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int LANES = 8;

    typedef logic [LANES-1:0][7:0] slice_t;

    typedef enum logic [1:0] {
        S_HDR_BLK,
        S_HDR_CNT,
        S_MASK,
        S_DATA
    } ldr_state_e;

    // index of the highest set bit; 0 for an empty mask
    function automatic logic [2:0] top_lane(input logic [LANES-1:0] m);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 0; i < LANES; i++) begin
            if (m[i]) r = 3'(i);
        end
        return r;
    endfunction

    function automatic logic single_bit(input logic [LANES-1:0] m);
        return (m != '0) && ((m & (m - 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/pcfg_mask_walker.sv
module pcfg_mask_walker
    import pcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LANES-1:0] load_mask,
    input  logic             take,
    output logic [2:0]       lane,
    output logic             last
);
    logic [LANES-1:0] pending;

    assign lane = top_lane(pending);
    assign last = single_bit(pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (load) begin
            pending <= load_mask;
        end else if (take) begin
            pending <= pending & ~(LANES'(1) << lane);
        end
    end
endmodule

// File: rtl/pcfg_frame_store.sv
module pcfg_frame_store
    import pcfg_pkg::*;
#(
    parameter int DEPTH = 224,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  slice_t           wdata,
    input  logic [IDX_W-1:0] raddr_a,
    output slice_t           rdata_a,
    input  logic [IDX_W-1:0] raddr_b,
    output slice_t           rdata_b
);
    slice_t mem [DEPTH];

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
    import pcfg_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int FRAME_BYTES = 56,
    localparam int FRM_W = $clog2(NUM_BLOCKS * LANES),
    localparam int OFF_W = $clog2(FRAME_BYTES),
    localparam int DEPTH = NUM_BLOCKS * FRAME_BYTES,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             busy,
    output logic             err,
    input  logic [FRM_W-1:0] rd_frame,
    input  logic [OFF_W-1:0] rd_byte,
    output logic [7:0]       rd_data
);
    ldr_state_e       st;
    logic [7:0]       start_blk;
    logic [7:0]       blk;
    logic [7:0]       left;
    logic [OFF_W-1:0] slice;
    slice_t           fdr;
    slice_t           merged;
    slice_t           cur_slice;
    slice_t           rd_slice;
    logic [2:0]       lane;
    logic             mask_last;
    logic             mem_we;
    logic             step;
    logic             over;
    logic             vec_phase;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] rd_idx;

    assign busy      = (st == S_MASK) || (st == S_DATA);
    assign vec_phase = (st == S_MASK);
    assign over      = ({1'b0, start_blk} + {1'b0, in_byte}) > 9'(NUM_BLOCKS);
    assign cur_idx   = IDX_W'(int'(blk) * FRAME_BYTES + int'(slice));
    assign rd_idx    = IDX_W'(int'(rd_frame >> 3) * FRAME_BYTES + int'(rd_byte));
    assign rd_data   = rd_slice[rd_frame[2:0]];

    always_comb begin
        merged       = fdr;
        merged[lane] = in_byte;
    end

    assign mem_we = in_valid && (st == S_DATA) && mask_last;
    assign step   = in_valid && (((st == S_MASK) && (in_byte == 8'h00)) || mem_we);

    pcfg_mask_walker u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (in_valid && (st == S_MASK) && (in_byte != 8'h00)),
        .load_mask (in_byte),
        .take      (in_valid && (st == S_DATA)),
        .lane      (lane),
        .last      (mask_last)
    );

    pcfg_frame_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (mem_we),
        .waddr   (cur_idx),
        .wdata   (merged),
        .raddr_a (cur_idx),
        .rdata_a (cur_slice),
        .raddr_b (rd_idx),
        .rdata_b (rd_slice)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_HDR_BLK;
            start_blk <= '0;
            blk       <= '0;
            left      <= '0;
            slice     <= '0;
            err       <= 1'b0;
            fdr       <= '0;
        end else if (in_valid) begin
            case (st)
                S_HDR_BLK: begin
                    start_blk <= in_byte;
                    err       <= 1'b0;
                    st        <= S_HDR_CNT;
                end
                S_HDR_CNT: begin
                    if (over) begin
                        err <= 1'b1;
                        st  <= S_HDR_BLK;
                    end else if (in_byte == 8'h00) begin
                        st <= S_HDR_BLK;
                    end else begin
                        blk   <= start_blk;
                        left  <= in_byte;
                        slice <= '0;
                        st    <= S_MASK;
                    end
                end
                S_MASK: begin
                    if (in_byte != 8'h00) begin
                        fdr <= cur_slice;
                        st  <= S_DATA;
                    end
                end
                default: begin
                    fdr <= merged;
                end
            endcase
            if (step) begin
                if (slice == OFF_W'(FRAME_BYTES - 1)) begin
                    slice <= '0;
                    if (left == 8'd1) begin
                        st <= S_HDR_BLK;
                    end else begin
                        blk  <= blk + 8'd1;
                        left <= left - 8'd1;
                        st   <= S_MASK;
                    end
                end else begin
                    slice <= slice + 1'b1;
                    st    <= S_MASK;
                end
            end
        end
    end
endmodule

// File: rtl/pcfg_loader_chk.sv
module pcfg_loader_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       busy,
    input logic       err,
    input logic       mem_we,
    input logic       vec_phase
);
    // R1
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !err));

    // R7
    a_r7_err_not_busy: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    // R5
    a_r5_zero_mask_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_phase && in_byte == 8'h00) |-> !mem_we);

    // R9
    a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> !mem_we);

    // R9
    a_r9_idle_busy_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(busy));

    // R6
    a_r6_write_in_walk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);
endmodule

bind pcfg_loader pcfg_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .busy      (busy),
    .err       (err),
    .mem_we    (mem_we),
    .vec_phase (vec_phase)
);

// File: tb/pcfg_loader_bench.sv
module pcfg_loader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int FB = 56;
    localparam int NF = NB * 8;
    localparam int FRM_W = $clog2(NF);
    localparam int OFF_W = $clog2(FB);

    // each entry: start block, block count, pattern seed
    localparam logic [23:0] XFER_TAB [4] = '{
        {8'd0, 8'd1, 8'd11},
        {8'd1, 8'd3, 8'd22},
        {8'd2, 8'd2, 8'd33},
        {8'd3, 8'd1, 8'd44}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_byte = 8'h00;
    logic             busy;
    logic             err;
    logic [FRM_W-1:0] rd_frame = '0;
    logic [OFF_W-1:0] rd_byte = '0;
    logic [7:0]       rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [NF][FB];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcfg_loader #(.NUM_BLOCKS(NB), .FRAME_BYTES(FB)) u_pcfg_loader (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .busy(busy), .err(err), .rd_frame(rd_frame), .rd_byte(rd_byte),
        .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic peek(input int f, input int o, output logic [7:0] v);
        rd_frame = FRM_W'(f);
        rd_byte  = OFF_W'(o);
        #1;
        v = rd_data;
    endtask

    task automatic compare_all(input string req);
        int bad = 0;
        int fa = 0, ea = 0;
        logic [7:0] v;
        for (int f = 0; f < NF; f++) begin
            for (int o = 0; o < FB; o++) begin
                peek(f, o, v);
                if (v !== model[f][o]) begin
                    if (bad == 0) begin fa = int'(v); ea = int'(model[f][o]); end
                    bad++;
                end
            end
        end
        chk(bad == 0, req, fa, ea);
    endtask

    function automatic logic [7:0] mask_of(input int seed, input int b, input int s);
        if ((s + b) % 5 == 0) return 8'h00;
        return 8'(seed * 37 + b * 13 + s * 7);
    endfunction

    function automatic logic [7:0] data_of(input int seed, input int b, input int s, input int k);
        return 8'(seed + b * 31 + s * 11 + k * 3) ^ 8'h5A;
    endfunction

    // sends one slice and updates the model, highest flagged frame first
    task automatic send_slice(input int b, input int s, input logic [7:0] m, input int seed);
        int k = 0;
        send(m);
        for (int j = 7; j >= 0; j--) begin
            if (m[j]) begin
                model[b*8+j][s] = data_of(seed, b, s, k);
                send(data_of(seed, b, s, k));
                k++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int f = 0; f < NF; f++)
            for (int o = 0; o < FB; o++) model[f][o] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(err == 1'b0, "R1 err", int'(err), 0);
        compare_all("R1 store cleared");

        // table walk: R3 slice order and frame mapping, R6 block chaining
        for (int t = 0; t < 4; t++) begin
            int sb   = int'(XFER_TAB[t][23:16]);
            int cnt  = int'(XFER_TAB[t][15:8]);
            int seed = int'(XFER_TAB[t][7:0]);
            send(8'(sb));
            chk(busy == 1'b0, "R2 idle after start byte", int'(busy), 0);
            send(8'(cnt));
            chk(busy == 1'b1, "R2 busy after count byte", int'(busy), 1);
            for (int b = sb; b < sb + cnt; b++)
                for (int s = 0; s < FB; s++)
                    send_slice(b, s, mask_of(seed, b, s), seed);
            chk(busy == 1'b0, "R6 busy falls after last block", int'(busy), 0);
            compare_all("R3 R6 store contents after transfer");
        end

        // R4 ordering, R5 zero mask, R9 idle gaps, R10 readback timing
        send(8'd0);
        send(8'd1);
        send(8'b1000_0101);
        send(8'hA1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R9 busy held over gap", int'(busy), 1);
        send(8'hB2);
        send(8'hC3);
        model[7][0] = 8'hA1;
        model[2][0] = 8'hB2;
        model[0][0] = 8'hC3;
        peek(7, 0, v); chk(v == 8'hA1, "R4 highest bit gets first byte", int'(v), 'hA1);
        peek(2, 0, v); chk(v == 8'hB2, "R4 middle bit", int'(v), 'hB2);
        peek(0, 0, v); chk(v == 8'hC3, "R10 lowest bit visible after last byte", int'(v), 'hC3);
        peek(1, 0, v); chk(v == model[1][0], "R4 unflagged frame kept", int'(v), int'(model[1][0]));
        send(8'h00);
        send(8'h01);
        send(8'hD4);
        model[0][2] = 8'hD4;
        peek(0, 2, v); chk(v == 8'hD4, "R5 zero mask takes no data byte", int'(v), 'hD4);
        for (int s = 3; s < FB; s++) send(8'h00);
        chk(busy == 1'b0, "R6 walk ends", int'(busy), 0);
        compare_all("R5 R9 store after skipped slices");

        // R7 range error
        send(8'd3);
        send(8'd2);
        chk(err == 1'b1, "R7 err raised", int'(err), 1);
        chk(busy == 1'b0, "R7 no walk", int'(busy), 0);
        send(8'd0);
        chk(err == 1'b0, "R7 err cleared by start byte", int'(err), 0);

        // R8 zero count
        send(8'd0);
        chk(busy == 1'b0, "R8 zero count idle", int'(busy), 0);
        chk(err == 1'b0, "R8 zero count no err", int'(err), 0);
        send(8'h55);
        send(8'h66);
        compare_all("R7 R8 store unchanged");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule